// File: doc/BRIEF.md
# Load Compressibility Predictor Table

This block predicts whether cache blocks brought in by a particular load instruction are likely to compress well. A last-level cache controller uses the prediction on a miss to decide whether to also prefetch the neighbouring sub-blocks of the same super-block. The prediction is kept per load instruction, not per address. The reasoning is that one instruction tends to touch data of one type, so its past refills are a good guide to its future ones.

The table is set-associative. The set index is a hash of the load's program counter, and each way holds a partial PC tag, a saturating confidence counter and the outcome of the most recent refill. There are two ports. The lookup port takes a PC and answers one cycle later with hit, predict-compressible and last-outcome. The update port takes a PC and a compressible flag from a memory refill response, and it trains or allocates an entry. Only updates change the table. Only updates count as use for the least-recently-used replacement order.

Top module: `cpt_table`

## Requirements
- R1: After reset every entry is invalid: a lookup misses, and `rsp_hit`, `rsp_pred` and `rsp_last` read 0.
- R2: `rsp_valid` is 1 exactly in the cycle after `lk_req` was 1. When `rsp_valid` is 0, `rsp_hit`, `rsp_pred` and `rsp_last` are 0.
- R3: The set of a PC is PC[9:2] XOR PC[17:10], and its tag is PC[47:8]. A lookup hits only if a valid way of that set holds that tag.
- R4: On a hit, `rsp_pred` is 1 when the 4-bit counter of the entry is 8 or more. A miss gives `rsp_pred` 0.
- R5: An update that hits raises the counter by one when the block is compressible and lowers it by one otherwise. The counter saturates at 15 and at 0.
- R6: An update that misses allocates a way of the set, with the counter set to 8 if the block is compressible and to 7 otherwise.
- R7: The way allocated is an invalid way if the set has one; otherwise it is the way whose last update is oldest. Every update, hit or allocation, makes its way the most recent.
- R8: When a lookup and an update arrive in the same cycle, the lookup answer reflects that update.
- R9: A lookup changes no state: it does not alter counters, last outcomes or the replacement order.
- R10: On a hit, `rsp_last` is the compressible flag of the latest update to that entry. A miss gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 48 | PC of the load being looked up |
| upd_req | input | 1 | Training update from a refill response |
| upd_pc | input | 48 | PC carried by the refill |
| upd_compressible | input | 1 | Refilled block was compressible |
| rsp_valid | output | 1 | Lookup answer present (one cycle after `lk_req`) |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_pred | output | 1 | Predict compressible |
| rsp_last | output | 1 | Outcome of the entry's latest refill |

## Verification
The bench drives the counter into both saturation limits and back across the threshold. A design that wraps instead of saturating would flip its prediction at the wrong moment. A lookup and an update to the same PC are issued in the same cycle; a design that reads the table before writing it would report a miss there. The eviction test touches the oldest way with a lookup just before an allocation. A design that let lookups refresh the recency order would then evict the wrong entry. A long random phase hammers two sets with six PCs each, so allocation, eviction order and the hashed set selection are all checked against the reference model.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int unsigned CPT_PC_W  = 48;
  localparam int unsigned CPT_TAG_W = 40;
  localparam int unsigned CPT_SETS  = 256;
  localparam int unsigned CPT_WAYS  = 4;
  localparam int unsigned CPT_CTR_W = 4;

  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_TRAIN = 2'd1,
    UPD_ALLOC = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/cpt_hash.sv
module cpt_hash #(
  parameter int unsigned PC_W  = 48,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 40
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  // fold two adjacent fields above the word offset
  assign idx = pc[IDX_W+1:2] ^ pc[2*IDX_W+1:IDX_W+2];
  assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/cpt_match.sv
module cpt_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 40,
  parameter int unsigned CTR_W = 4
) (
  input  logic [TAG_W-1:0]            tag,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][CTR_W-1:0]  ctrs,
  input  logic [WAYS-1:0]             bits,
  output logic                        hit,
  output logic                        pred,
  output logic                        last
);
  localparam logic [CTR_W-1:0] THRESH = CTR_W'(1) << (CTR_W-1);

  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld[w] && (tags[w] == tag);
  end

  always_comb begin
    hit  = |way_hit;
    pred = 1'b0;
    last = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        pred = pred | (ctrs[w] >= THRESH);
        last = last | bits[w];
      end
    end
  end
endmodule

// File: rtl/cpt_set_update.sv
module cpt_set_update
  import cpt_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 40,
  parameter int unsigned CTR_W = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0]            tag,
  input  logic                        flag,
  input  logic [WAYS-1:0]             cur_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  cur_tag,
  input  logic [WAYS-1:0][CTR_W-1:0]  cur_ctr,
  input  logic [WAYS-1:0]             cur_bit,
  input  logic [WAYS-1:0][WAY_W-1:0]  cur_age,
  output upd_kind_e                   kind,
  output logic [WAYS-1:0]             nxt_vld,
  output logic [WAYS-1:0][TAG_W-1:0]  nxt_tag,
  output logic [WAYS-1:0][CTR_W-1:0]  nxt_ctr,
  output logic [WAYS-1:0]             nxt_bit,
  output logic [WAYS-1:0][WAY_W-1:0]  nxt_age
);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_HI   = CTR_W'(1) << (CTR_W-1);
  localparam logic [CTR_W-1:0] CTR_LO   = CTR_HI - CTR_W'(1);
  localparam logic [WAY_W-1:0] AGE_OLD  = WAY_W'(WAYS-1);

  logic [WAYS-1:0] hit_v, old_v, sel_v;
  logic [WAY_W-1:0] sel_age;
  logic any_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_v[w] = cur_vld[w] && (cur_tag[w] == tag);
    assign old_v[w] = (cur_age[w] == AGE_OLD);
  end

  assign any_hit = |hit_v;
  assign sel_v   = any_hit ? hit_v : old_v;
  assign kind    = any_hit ? UPD_TRAIN : UPD_ALLOC;

  always_comb begin
    sel_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_v[w]) sel_age = sel_age | cur_age[w];
    end
  end

  always_comb begin
    nxt_vld = cur_vld;
    nxt_tag = cur_tag;
    nxt_ctr = cur_ctr;
    nxt_bit = cur_bit;
    nxt_age = cur_age;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_v[w]) begin
        nxt_vld[w] = 1'b1;
        nxt_tag[w] = tag;
        nxt_bit[w] = flag;
        nxt_age[w] = '0;
        if (!any_hit)
          nxt_ctr[w] = flag ? CTR_HI : CTR_LO;
        else if (flag && (cur_ctr[w] != CTR_MAX))
          nxt_ctr[w] = cur_ctr[w] + CTR_W'(1);
        else if (!flag && (cur_ctr[w] != '0))
          nxt_ctr[w] = cur_ctr[w] - CTR_W'(1);
      end else if (cur_age[w] < sel_age) begin
        nxt_age[w] = cur_age[w] + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpt_table.sv
module cpt_table
  import cpt_pkg::*;
#(
  parameter int unsigned PC_W  = CPT_PC_W,
  parameter int unsigned TAG_W = CPT_TAG_W,
  parameter int unsigned SETS  = CPT_SETS,
  parameter int unsigned WAYS  = CPT_WAYS,
  parameter int unsigned CTR_W = CPT_CTR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_req,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            upd_req,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_compressible,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_pred,
  output logic            rsp_last
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // storage
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][CTR_W-1:0] ctr_q [SETS];
  logic [WAYS-1:0]            bit_q [SETS];

  logic [IDX_W-1:0] u_idx, l_idx;
  logic [TAG_W-1:0] u_tag, l_tag;

  cpt_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_upd (
    .pc(upd_pc), .idx(u_idx), .tag(u_tag)
  );
  cpt_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .pc(lk_pc), .idx(l_idx), .tag(l_tag)
  );

  // update path: next contents of the trained set
  upd_kind_e                  u_kind;
  logic [WAYS-1:0]            n_vld, n_bit;
  logic [WAYS-1:0][TAG_W-1:0] n_tag;
  logic [WAYS-1:0][CTR_W-1:0] n_ctr;
  logic [WAYS-1:0][WAY_W-1:0] n_age;

  cpt_set_update #(.WAYS(WAYS), .TAG_W(TAG_W), .CTR_W(CTR_W)) u_upd (
    .tag(u_tag), .flag(upd_compressible),
    .cur_vld(vld_q[u_idx]), .cur_tag(tag_q[u_idx]), .cur_ctr(ctr_q[u_idx]),
    .cur_bit(bit_q[u_idx]), .cur_age(age_q[u_idx]),
    .kind(u_kind),
    .nxt_vld(n_vld), .nxt_tag(n_tag), .nxt_ctr(n_ctr),
    .nxt_bit(n_bit), .nxt_age(n_age)
  );

  // lookup path sees this cycle's update first
  logic                       fwd;
  logic [WAYS-1:0]            s_vld, s_bit;
  logic [WAYS-1:0][TAG_W-1:0] s_tag;
  logic [WAYS-1:0][CTR_W-1:0] s_ctr;
  logic                       m_hit, m_pred, m_last;

  always_comb begin
    fwd = upd_req && (u_kind != UPD_IDLE) && (u_idx == l_idx);
    if (fwd) begin
      s_vld = n_vld; s_tag = n_tag; s_ctr = n_ctr; s_bit = n_bit;
    end else begin
      s_vld = vld_q[l_idx]; s_tag = tag_q[l_idx];
      s_ctr = ctr_q[l_idx]; s_bit = bit_q[l_idx];
    end
  end

  cpt_match #(.WAYS(WAYS), .TAG_W(TAG_W), .CTR_W(CTR_W)) u_match (
    .tag(l_tag), .vld(s_vld), .tags(s_tag), .ctrs(s_ctr), .bits(s_bit),
    .hit(m_hit), .pred(m_pred), .last(m_last)
  );

  // response next-state
  logic rv_d, rh_d, rp_d, rl_d;
  always_comb begin
    rv_d = lk_req;
    rh_d = lk_req && m_hit;
    rp_d = lk_req && m_hit && m_pred;
    rl_d = lk_req && m_hit && m_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pred  <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= rv_d;
      rsp_hit   <= rh_d;
      rsp_pred  <= rp_d;
      rsp_last  <= rl_d;
    end
  end

  // control state: valid bits and recency, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (upd_req) begin
      vld_q[u_idx] <= n_vld;
      age_q[u_idx] <= n_age;
    end
  end

  // payload: no reset, written under update enable
  always_ff @(posedge clk) begin
    if (upd_req) begin
      tag_q[u_idx] <= n_tag;
      ctr_q[u_idx] <= n_ctr;
      bit_q[u_idx] <= n_bit;
    end
  end
endmodule

// File: rtl/cpt_table_chk.sv
module cpt_table_chk #(
  parameter int unsigned PC_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [PC_W-1:0] lk_pc,
  input logic            upd_req,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_compressible,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_pred,
  input logic            rsp_last
);
  // R2
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_pred && !rsp_last));

  // R4
  pred_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pred |-> rsp_hit);

  // R10
  last_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_hit);

  // R8
  same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && upd_req && (lk_pc == upd_pc)) |=> rsp_hit);

  // R10
  same_cycle_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && upd_req && (lk_pc == upd_pc)) |=> (rsp_last == $past(upd_compressible)));
endmodule

bind cpt_table cpt_table_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/cpt_table_tb.sv
`timescale 1ns/1ps
module cpt_table_tb;
  logic        clk;
  logic        rst_n;
  logic        lk_req, upd_req, upd_compressible;
  logic [47:0] lk_pc, upd_pc;
  logic        rsp_valid, rsp_hit, rsp_pred, rsp_last;

  cpt_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_pc(lk_pc),
    .upd_req(upd_req), .upd_pc(upd_pc), .upd_compressible(upd_compressible),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pred(rsp_pred), .rsp_last(rsp_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec  = 0;
  int n_miss = 0;
  int cyc    = 0;

  // behavioural reference model
  bit          mv [256][4];
  logic [39:0] mt [256][4];
  int          mc [256][4];
  bit          mb [256][4];
  longint      ms [256][4];
  longint      now = 0;

  bit    e_v, e_h, e_p, e_l;
  string e_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_miss++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  function automatic logic [47:0] mkpc(logic [39:0] t, logic [7:0] s);
    logic [39:0] tt;
    logic [5:0]  lo;
    tt = t;
    tt[1:0] = s[7:6] ^ t[9:8];
    lo = s[5:0] ^ tt[7:2];
    return {tt, lo, 2'b00};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 0; mt[s][w] = '0; mc[s][w] = 0; mb[s][w] = 0; ms[s][w] = -1;
      end
  endtask

  task automatic model_update(logic [47:0] pc, bit fl);
    int s, hw, vw;
    logic [39:0] t;
    s = int'(pc[9:2] ^ pc[17:10]);
    t = pc[47:8];
    hw = -1;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
    if (hw >= 0) begin
      if (fl) mc[s][hw] = (mc[s][hw] < 15) ? mc[s][hw] + 1 : 15;
      else    mc[s][hw] = (mc[s][hw] > 0)  ? mc[s][hw] - 1 : 0;
      mb[s][hw] = fl;
      ms[s][hw] = now++;
    end else begin
      vw = 0;
      for (int w = 1; w < 4; w++) if (ms[s][w] < ms[s][vw]) vw = w;
      mv[s][vw] = 1; mt[s][vw] = t; mc[s][vw] = fl ? 8 : 7;
      mb[s][vw] = fl; ms[s][vw] = now++;
    end
  endtask

  task automatic model_lookup(logic [47:0] pc);
    int s;
    logic [39:0] t;
    s = int'(pc[9:2] ^ pc[17:10]);
    t = pc[47:8];
    e_h = 0; e_p = 0; e_l = 0;
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mt[s][w] == t) begin
        e_h = 1; e_p = (mc[s][w] >= 8); e_l = mb[s][w];
      end
  endtask

  task automatic step(bit lk, logic [47:0] lpc, bit up, logic [47:0] upc, bit fl, string tag);
    @(negedge clk);
    n_vec++;
    if ({rsp_valid, rsp_hit, rsp_pred, rsp_last} !== {e_v, e_h, e_p, e_l}) begin
      n_miss++;
      $display("FAIL %s: actual v/h/p/l=%b%b%b%b expected=%b%b%b%b",
               e_tag, rsp_valid, rsp_hit, rsp_pred, rsp_last, e_v, e_h, e_p, e_l);
    end
    lk_req = lk; lk_pc = lpc; upd_req = up; upd_pc = upc; upd_compressible = fl;
    if (up) model_update(upc, fl);     // R8: update precedes same-cycle lookup
    e_v = lk;
    if (lk) model_lookup(lpc);
    else begin e_h = 0; e_p = 0; e_l = 0; end
    e_tag = tag;
  endtask

  logic [47:0] pa, pb, pc_c, pd, pe, px;

  initial begin
    rst_n = 1'b0; lk_req = 0; upd_req = 0; upd_compressible = 0;
    lk_pc = '0; upd_pc = '0;
    e_v = 0; e_h = 0; e_p = 0; e_l = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    pa   = mkpc(40'h00_1234_5600, 8'h05);
    pb   = mkpc(40'h00_2222_0000, 8'h05);
    pc_c = mkpc(40'h00_3333_0000, 8'h05);
    pd   = mkpc(40'h00_4444_0000, 8'h05);
    pe   = mkpc(40'h00_5555_0000, 8'h05);

    // R1 reset state and an empty-table lookup
    step(0, '0, 0, '0, 0, "R1");
    step(1, pa, 0, '0, 0, "R1");
    step(0, '0, 0, '0, 0, "R2");
    // R6 allocation values
    step(0, '0, 1, pa, 1, "R6");
    step(1, pa, 0, '0, 0, "R6");
    step(0, '0, 1, pb, 0, "R6");
    step(1, pb, 0, '0, 0, "R6");
    // R5 threshold crossing from allocation
    step(0, '0, 1, pb, 1, "R5");
    step(1, pb, 0, '0, 0, "R5");
    // R5 saturate high, then fall through threshold
    for (int i = 0; i < 10; i++) step(1, pa, 1, pa, 1, "R5");
    for (int i = 0; i < 9; i++)  step(1, pa, 1, pa, 0, "R5");
    // R5 saturate low, then climb back (R10 last flag follows)
    for (int i = 0; i < 20; i++) step(1, pa, 1, pa, 0, "R5");
    for (int i = 0; i < 9; i++)  step(1, pa, 1, pa, 1, "R10");
    // R8 same-cycle allocate and lookup
    step(1, pc_c, 1, pc_c, 1, "R8");
    step(1, pc_c, 0, '0, 0, "R8");
    // R3 same tag other set, other tag same set
    step(1, mkpc(40'h00_1234_5600, 8'h06), 0, '0, 0, "R3");
    step(1, mkpc(40'h00_7777_0000, 8'h05), 0, '0, 0, "R3");
    // R7/R9: fill last way, lookup oldest, allocate fifth
    step(0, '0, 1, pd, 0, "R7");
    step(1, pb, 0, '0, 0, "R9");
    step(0, '0, 1, pe, 1, "R7");
    step(1, pb, 0, '0, 0, "R9");
    step(1, pa, 0, '0, 0, "R7");
    step(1, pc_c, 0, '0, 0, "R7");
    step(1, pd, 0, '0, 0, "R7");
    step(1, pe, 0, '0, 0, "R7");

    // random phase: six PCs per set in two sets
    for (int i = 0; i < 3000; i++) begin
      bit lk, up, fl;
      logic [7:0] ls, us;
      lk = ($urandom % 2) == 0;
      up = ($urandom % 3) != 0;
      fl = ($urandom % 4) != 0;
      ls = (($urandom % 2) == 0) ? 8'h11 : 8'hA2;
      us = (($urandom % 2) == 0) ? 8'h11 : 8'hA2;
      px = mkpc(40'h00_0100_0000 + 40'(($urandom % 6) << 12), us);
      step(lk, mkpc(40'h00_0100_0000 + 40'(($urandom % 6) << 12), ls),
           up, px, fl, "R7");
    end
    step(0, '0, 0, '0, 0, "R2");
    step(0, '0, 0, '0, 0, "R2");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule